// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block scans a keypad of `LINES` by `RETURNS` switches (8 by 4 by default, 32 keys). A free-running frame counter opens a scan window at the start of every frame. Inside the window the block pulls each active-low scan line low in turn, from line 0 to the highest line. Every line is held for `STROBE_CLKS` clocks. The return inputs idle high and read low where a closed switch joins them to the line that is being driven.

Each return bus is sampled once per strobe, three quarters of the way through it. The first scan line that shows a closed switch is captured in full. Two clocks after the window closes, the result goes into a key register that stays steady for the host. A request output tells the host that a press was seen.

A read-busy input from the host interface keeps the register frozen across the load point while a read is under way. The key register is a held level and not a transfer, so the block has no valid/ready handshake. The host reads it whenever the request tells it to. A scan-enable input turns detection off. The window still runs, but no line is driven and the returns are ignored.

Top module: `kpad_scan`

## Requirements
- R1: Inside the window at the start of each `FRAME_CLKS`-clock frame, `scan_n` drives exactly one line low at a time. The lines run in ascending order, 0 first, and each is held for `STROBE_CLKS` clocks. `scan_win` is high for the `LINES*STROBE_CLKS` clocks of the window, and every line is high outside it.
- R2: The returns are sampled only in the clock with phase index `(STROBE_CLKS*3)/4` (index 3 of 0..3 by default) of each strobe. A low return seen only in the earlier phases is not detected.
- R3: Key register format: bits 7..4 are flags for returns 3..0, where 1 means that return was pulled low. Bit 3 is always 0. Bits 2..0 hold the binary number of the scan line that was reported.
- R4: After reset, and after any frame with no press, the key register reads 0x00. `key_req` is 0 after reset.
- R5: All returns that are low on the reported line appear together in the flag bits.
- R6: When presses appear on several lines in one frame, only the lowest-numbered line is reported, with that line's flags alone.
- R7: The key register keeps its old value in the first clock after the window ends and shows the new result from the second clock on. It then holds until the next load.
- R8: If `read_busy` is high at the load point, the key register is not updated and keeps its previous value.
- R9: `key_req` rises the clock after a press is captured. It stays high until it drops two clocks before the next window opens, so it is low in the last two clocks of the frame.
- R10: With `scan_en` low for a frame, all scan lines stay high and the returns are not sampled, even when they are held low. That frame loads 0x00 and `key_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | 1 enables scanning and detection |
| read_busy | input | 1 | Host read of the key register is in progress |
| key_ret_n | input | RETURNS | Active-low return inputs, one per keypad column |
| scan_n | output | LINES | Active-low scan line strobes |
| scan_win | output | 1 | High during the scan window of each frame |
| key_code | output | RETURNS+1+clog2(LINES) | Held key register |
| key_req | output | 1 | Key-press request to the host |

## Verification
The bench models the keypad as a switch matrix driven by the block's own strobes. On some frames it pulses a return low only in chosen strobe phases. A block that sampled too early would then report a key in the frame where the pulse ends before the late phase, and one that sampled late would miss a key. Frames with presses on two lines catch a design that reports the last line, or that merges flags from different lines. A frame that holds `read_busy` across the load catches a register that is overwritten during a host read. The two-clock load delay and the early drop of the request are checked at the exact clock on each side, so an off-by-one in either would show. A disabled frame with the returns held low catches a detector that still samples when scanning is off.

// File: rtl/kpad_pkg.sv
package kpad_pkg;

  // Frame timing events, each true for one clock of the frame
  typedef struct packed {
    logic sample;    // late phase of the current strobe
    logic load;      // key register update point
    logic req_clr;   // request drop point
    logic win_open;  // last clock before the window opens
  } kp_evt_t;

  localparam int unsigned DEF_LINES       = 8;
  localparam int unsigned DEF_RETURNS     = 4;
  localparam int unsigned DEF_STROBE_CLKS = 4;
  localparam int unsigned DEF_FRAME_CLKS  = 64;

endpackage

// File: rtl/kpad_timer.sv
module kpad_timer
  import kpad_pkg::*;
#(
  parameter int unsigned LINES       = DEF_LINES,
  parameter int unsigned STROBE_CLKS = DEF_STROBE_CLKS,
  parameter int unsigned FRAME_CLKS  = DEF_FRAME_CLKS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scan_en,
  output logic [LINES-1:0]          scan_n,
  output logic                      scan_win,
  output logic [$clog2(LINES)-1:0]  line_idx,
  output kp_evt_t                   evt
);

  localparam int unsigned WIN       = LINES * STROBE_CLKS;
  localparam int unsigned CW        = $clog2(FRAME_CLKS);
  localparam int unsigned LW        = $clog2(LINES);
  localparam int unsigned PW        = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
  localparam int unsigned SAMPLE_AT = (STROBE_CLKS * 3) / 4;

  localparam logic [CW-1:0] LAST_C  = CW'(FRAME_CLKS - 1);
  localparam logic [CW-1:0] WIN_C   = CW'(WIN);
  localparam logic [CW-1:0] LOAD_C  = CW'(WIN + 1);
  localparam logic [CW-1:0] CLR_C   = CW'(FRAME_CLKS - 3);
  localparam logic [PW-1:0] PH_LAST = PW'(STROBE_CLKS - 1);
  localparam logic [PW-1:0] PH_SMP  = PW'(SAMPLE_AT);
  localparam logic [LW-1:0] LN_LAST = LW'(LINES - 1);

  logic [CW-1:0] fcnt;
  logic [PW-1:0] ph;
  logic [LW-1:0] ln;
  logic          in_win;

  assign in_win = (fcnt < WIN_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt <= '0;
      ph   <= '0;
      ln   <= '0;
    end else begin
      fcnt <= (fcnt == LAST_C) ? '0 : fcnt + CW'(1);
      if (in_win) begin
        if (ph == PH_LAST) begin
          ph <= '0;
          ln <= (ln == LN_LAST) ? '0 : ln + LW'(1);
        end else begin
          ph <= ph + PW'(1);
        end
      end else begin
        ph <= '0;
        ln <= '0;
      end
    end
  end

  always_comb begin
    evt.sample   = in_win && (ph == PH_SMP);
    evt.load     = (fcnt == LOAD_C);
    evt.req_clr  = (fcnt == CLR_C);
    evt.win_open = (fcnt == LAST_C);
  end

  genvar gi;
  generate
    for (gi = 0; gi < LINES; gi++) begin : g_strobe
      assign scan_n[gi] = ~(scan_en && in_win && (ln == LW'(gi)));
    end
  endgenerate

  assign scan_win = in_win;
  assign line_idx = ln;

  // R1: lines never overlap
  p_one_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~scan_n));

  // R1: nothing driven outside the window
  p_quiet_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt >= WIN_C) |-> (&scan_n));

  // R1: each new strobe moves to the next line
  p_line_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && (ph == '0) && (fcnt != '0)) |-> (ln == $past(ln) + LW'(1)));

  // R10: disabled scanning drives no line
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> (&scan_n));

endmodule

// File: rtl/kpad_detect.sv
module kpad_detect #(
  parameter int unsigned LINES   = kpad_pkg::DEF_LINES,
  parameter int unsigned RETURNS = kpad_pkg::DEF_RETURNS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scan_en,
  input  logic                      sample,
  input  logic                      win_open,
  input  logic [$clog2(LINES)-1:0]  line_idx,
  input  logic [RETURNS-1:0]        ret_n,
  output logic                      found,
  output logic                      new_hit,
  output logic [RETURNS-1:0]        hit_flags,
  output logic [$clog2(LINES)-1:0]  hit_line
);

  logic [RETURNS-1:0] low_now;

  assign low_now = ~ret_n;
  // first line with a closed switch wins; later lines are ignored
  assign new_hit = sample && scan_en && !found && (|low_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      found     <= 1'b0;
      hit_flags <= '0;
      hit_line  <= '0;
    end else if (win_open) begin
      found     <= 1'b0;
      hit_flags <= '0;
      hit_line  <= '0;
    end else if (new_hit) begin
      found     <= 1'b1;
      hit_flags <= low_now;
      hit_line  <= line_idx;
    end
  end

  // R6: once a line is captured it is kept for the rest of the frame
  p_keep_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (found && !win_open) |=> (found && $stable(hit_line) && $stable(hit_flags)));

  // R10: no capture while scanning is disabled
  p_no_capture_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !found) |=> !found);

endmodule

// File: rtl/kpad_keyreg.sv
module kpad_keyreg #(
  parameter int unsigned LINES   = kpad_pkg::DEF_LINES,
  parameter int unsigned RETURNS = kpad_pkg::DEF_RETURNS
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  load,
  input  logic                                  req_clr,
  input  logic                                  read_busy,
  input  logic                                  found,
  input  logic                                  new_hit,
  input  logic [RETURNS-1:0]                    hit_flags,
  input  logic [$clog2(LINES)-1:0]              hit_line,
  output logic [RETURNS+$clog2(LINES):0]        key_code,
  output logic                                  key_req
);

  localparam int unsigned LW = $clog2(LINES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_code <= '0;
    end else if (load && !read_busy) begin
      key_code <= found ? {hit_flags, 1'b0, hit_line} : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_req <= 1'b0;
    end else if (new_hit) begin
      key_req <= 1'b1;
    end else if (req_clr) begin
      key_req <= 1'b0;
    end
  end

  // R8: a host read in progress freezes the register
  p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    read_busy |=> $stable(key_code));

  // R7: the register moves only at the load point
  p_load_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(key_code) |-> $past(load));

  // R3: separator bit is always clear
  p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    key_code[LW] == 1'b0);

  // R9: request follows a capture and drops only at its clear point
  p_req_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    new_hit |=> key_req);
  p_req_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(key_req) |-> $past(req_clr));

endmodule

// File: rtl/kpad_scan.sv
module kpad_scan
  import kpad_pkg::*;
#(
  parameter int unsigned LINES       = DEF_LINES,
  parameter int unsigned RETURNS     = DEF_RETURNS,
  parameter int unsigned STROBE_CLKS = DEF_STROBE_CLKS,
  parameter int unsigned FRAME_CLKS  = DEF_FRAME_CLKS
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                scan_en,
  input  logic                                read_busy,
  input  logic [RETURNS-1:0]                  key_ret_n,
  output logic [LINES-1:0]                    scan_n,
  output logic                                scan_win,
  output logic [RETURNS+$clog2(LINES):0]      key_code,
  output logic                                key_req
);

  localparam int unsigned LW = $clog2(LINES);

  kp_evt_t            evt;
  logic [LW-1:0]      line_idx;
  logic               found;
  logic               new_hit;
  logic [RETURNS-1:0] hit_flags;
  logic [LW-1:0]      hit_line;

  kpad_timer #(
    .LINES       (LINES),
    .STROBE_CLKS (STROBE_CLKS),
    .FRAME_CLKS  (FRAME_CLKS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .scan_n   (scan_n),
    .scan_win (scan_win),
    .line_idx (line_idx),
    .evt      (evt)
  );

  kpad_detect #(
    .LINES   (LINES),
    .RETURNS (RETURNS)
  ) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_en   (scan_en),
    .sample    (evt.sample),
    .win_open  (evt.win_open),
    .line_idx  (line_idx),
    .ret_n     (key_ret_n),
    .found     (found),
    .new_hit   (new_hit),
    .hit_flags (hit_flags),
    .hit_line  (hit_line)
  );

  kpad_keyreg #(
    .LINES   (LINES),
    .RETURNS (RETURNS)
  ) u_keyreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (evt.load),
    .req_clr   (evt.req_clr),
    .read_busy (read_busy),
    .found     (found),
    .new_hit   (new_hit),
    .hit_flags (hit_flags),
    .hit_line  (hit_line),
    .key_code  (key_code),
    .key_req   (key_req)
  );

endmodule

// File: tb/kpad_scan_test.sv
module kpad_scan_test;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            scan_en = 1'b1;
  logic            read_busy = 1'b0;
  logic [3:0]      key_ret_n;
  logic [7:0]      scan_n;
  logic            scan_win;
  logic [7:0]      key_code;
  logic            key_req;

  logic [7:0][3:0] press = '0;
  logic [3:0]      stuck = '0;
  logic [3:0]      glitch = '0;
  logic [7:0]      prev_code = 8'h00;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  kpad_scan uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_en   (scan_en),
    .read_busy (read_busy),
    .key_ret_n (key_ret_n),
    .scan_n    (scan_n),
    .scan_win  (scan_win),
    .key_code  (key_code),
    .key_req   (key_req)
  );

  // switch matrix: a closed switch pulls its return low while its line is driven
  always_comb begin
    logic [3:0] lo;
    lo = stuck | glitch;
    for (int i = 0; i < 8; i++) begin
      if (!scan_n[i]) lo = lo | press[i];
    end
    key_ret_n = ~lo;
  end

  task automatic check(input bit ok, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", what, act, exp);
    end
  endtask

  // lowest line with any low return, R3 format
  function automatic logic [7:0] expect_code(input logic [7:0][3:0] p, input bit en,
                                             input int gl_line, input bit gl_hit);
    logic [3:0] row;
    if (!en) return 8'h00;
    for (int i = 0; i < 8; i++) begin
      row = p[i] | ((gl_hit && i == gl_line) ? 4'b0001 : 4'b0000);
      if (row != 4'b0000) return {row, 1'b0, 3'(i)};
    end
    return 8'h00;
  endfunction

  task automatic run_frame(input logic [7:0][3:0] p, input bit en, input bit busy,
                           input logic [3:0] stk, input int gl_line, input logic [3:0] gl_mask,
                           input string tag);
    bit ok;
    logic [7:0] exp_strobe, new_code, exp_now;
    bit exp_req;
    press = p; scan_en = en; read_busy = busy; stuck = stk;
    @(posedge scan_win); #1;
    ok = 1;
    for (int l = 0; l < 8; l++) begin
      for (int ph = 0; ph < 4; ph++) begin
        exp_strobe = en ? ~(8'h01 << l) : 8'hFF;
        if (scan_n !== exp_strobe) ok = 0;
        if (scan_win !== 1'b1) ok = 0;
        glitch = (l == gl_line && gl_mask[ph]) ? 4'b0001 : 4'b0000;
        @(posedge clk); #1;
      end
    end
    glitch = '0;
    check(ok && scan_n === 8'hFF && scan_win === 1'b0,
          {"R1 strobe sequence (R10 when off) ", tag}, scan_n, 8'hFF);
    new_code = expect_code(p, en, gl_line, gl_mask[3]);
    exp_now  = busy ? prev_code : new_code;
    exp_req  = (new_code != 8'h00);
    @(posedge clk); #1;
    check(key_code === prev_code, {"R7 old value one clock after window ", tag}, key_code, prev_code);
    @(posedge clk); #1;
    check(key_code === exp_now, {"R2 R3 R4 R5 R6 R8 R10 key register ", tag}, key_code, exp_now);
    repeat (27) @(posedge clk);
    #1;
    check(key_code === exp_now, {"R7 register holds ", tag}, key_code, exp_now);
    check(key_req === exp_req, {"R9 request level ", tag}, {7'd0, key_req}, {7'd0, exp_req});
    read_busy = 1'b0;
    @(posedge clk); #1;
    check(key_req === 1'b0, {"R9 request low before window ", tag}, {7'd0, key_req}, 8'h00);
    prev_code = exp_now;
  endtask

  initial begin : watchdog
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0][3:0] p;
    bit en, busy;
    logic [3:0] stk;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1;
    check(key_code === 8'h00, "R4 reset key register", key_code, 8'h00);
    check(key_req === 1'b0, "R4 reset request", {7'd0, key_req}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge scan_win); #1;

    p = '0;                          run_frame(p, 1, 0, 4'h0, -1, 4'h0, "R4 idle");
    p = '0; p[2] = 4'b0100;          run_frame(p, 1, 0, 4'h0, -1, 4'h0, "R3 single key");
    p = '0; p[7] = 4'b1001;          run_frame(p, 1, 0, 4'h0, -1, 4'h0, "R5 same line pair");
    p = '0; p[3] = 4'b0010; p[6] = 4'b0100;
                                     run_frame(p, 1, 0, 4'h0, -1, 4'h0, "R6 two lines");
    p = '0; p[0] = 4'b1111; p[7] = 4'b0001;
                                     run_frame(p, 1, 0, 4'h0, -1, 4'h0, "R5 R6 full line zero");
    p = '0; p[5] = 4'b0010;          run_frame(p, 1, 1, 4'h0, -1, 4'h0, "R8 busy at load");
    p = '0;                          run_frame(p, 1, 0, 4'h0, -1, 4'h0, "R4 release");
    p = '0; p[1] = 4'b0110;          run_frame(p, 0, 0, 4'hF, -1, 4'h0, "R10 disabled stuck");
    p = '0; p[4] = 4'b1000;          run_frame(p, 1, 0, 4'h0, -1, 4'h0, "R10 re-enabled");
    p = '0;                          run_frame(p, 1, 0, 4'h0, 2, 4'b0111, "R2 early pulse");
    p = '0;                          run_frame(p, 1, 0, 4'h0, 5, 4'b1000, "R2 late pulse");
    p = '0; p[6] = 4'b0001;          run_frame(p, 1, 0, 4'h0, 3, 4'b1000, "R2 R6 pulse beats line 6");

    for (int f = 0; f < 30; f++) begin
      p = '0;
      for (int i = 0; i < 8; i++) begin
        if ($urandom % 6 == 0) p[i] = 4'($urandom);
      end
      en   = ($urandom % 8) != 0;
      busy = ($urandom % 5) == 0;
      stk  = en ? 4'h0 : 4'($urandom);
      run_frame(p, en, busy, stk, -1, 4'h0, "random frame");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule